// File: doc/BRIEF.md
# DMA channel transfer sequencer

This block is the control logic of one DMA channel. A start pulse captures a source base address, a destination base address, an access width for each side, two pointer-increment flags, a circular-mode flag and an item count. From then on the channel asks an external arbiter for service. Each grant moves exactly one item: one read at the source pointer, then one write at the destination pointer, both over a simple request/done memory port that can also answer with an error.

The two sides may have different widths. A narrow source item is zero-extended into a wider destination write. A wide source item is cut down to the low-order bytes that fit a narrower destination. The remaining-item counter drives three sticky events: reaching half of the programmed count, reaching zero, and an error. Each event has its own enable, and the enabled events are ORed into a single interrupt line. In circular mode the channel restarts from its base addresses with a full count and keeps running without any further start.

Top module: `dma_chan_seq`

## Requirements
- R1: A start pulse is accepted only while `ch_active` is low. On the next cycle `ch_active` is high and `cnt_left` holds the programmed count. A start pulse while `ch_active` is high is ignored.
- R2: Width codes are 2'b00 byte, 2'b01 half-word and 2'b10 word. Starting with code 2'b11 on either side sets `flag_err`, leaves `ch_active` low and issues no memory access.
- R3: `ch_req` is high when the channel is active, no item is in flight and `cnt_left` is nonzero. Each grant produces one read (`mem_we`=0) of the source width at the source pointer, followed by one write (`mem_we`=1) of the destination width at the destination pointer. Each access is held until `mem_done`.
- R4: A source or destination base address that is not a multiple of its own width (in bytes) sets `flag_err` at start and leaves the channel inactive.
- R5: Each completed write decrements `cnt_left` by one. A pointer advances by its own width in bytes after each item when its increment flag is set, and stays fixed otherwise.
- R6: Read data is taken from the low-order lanes of `mem_rdata` for the source width, and the upper lanes are ignored. The write data carries those bytes in little-endian order in the low lanes. Lanes beyond the source width are zero, and a narrower destination receives only the low-order bytes.
- R7: An error response (`mem_done` with `mem_err`) on a read or a write sets `flag_err` and drops `ch_active`. `cnt_left` keeps its value and no further access is issued.
- R8: `flag_half` sets when `cnt_left` falls to the programmed count divided by two, rounded down. `flag_done` sets when `cnt_left` reaches zero. Outside circular mode, `ch_active` then drops.
- R9: In circular mode, reaching zero sets `flag_done`, reloads `cnt_left` with the programmed count, returns both pointers to their bases and leaves the channel active.
- R10: Starting with a count of zero leaves the channel inactive. No access is issued and no event flag is set.
- R11: Event flags stay set until their clear input is pulsed. `irq` is high exactly when some flag is set and its enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture configuration and enable the channel |
| src_base | input | AW | Source base address |
| dst_base | input | AW | Destination base address |
| src_size | input | 2 | Source width code |
| dst_size | input | 2 | Destination width code |
| src_inc | input | 1 | Advance source pointer after each item |
| dst_inc | input | 1 | Advance destination pointer after each item |
| circ | input | 1 | Circular mode |
| item_count | input | CW | Number of items to move |
| ie_half | input | 1 | Enable for half event |
| ie_done | input | 1 | Enable for completion event |
| ie_err | input | 1 | Enable for error event |
| clr_half | input | 1 | Write-one-to-clear for half flag |
| clr_done | input | 1 | Write-one-to-clear for completion flag |
| clr_err | input | 1 | Write-one-to-clear for error flag |
| ch_gnt | input | 1 | Grant from the arbiter |
| ch_req | output | 1 | Service request to the arbiter |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_done | input | 1 | Access finished this cycle |
| mem_err | input | 1 | Access ended in error (valid with mem_done) |
| ch_active | output | 1 | Channel enabled |
| cnt_left | output | CW | Items remaining |
| flag_half | output | 1 | Half event flag |
| flag_done | output | 1 | Completion event flag |
| flag_err | output | 1 | Error event flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `mem_done` and `mem_err` are single-cycle pulses that appear only while `mem_req` is high, and that the arbiter grants only a pending `ch_req`. The bench's memory model answers each access exactly once, one cycle after seeing it, and derives the grant from `ch_req` at the falling edge, so both assumptions hold by construction of the stimulus. The model returns all four bytes at the address for every read, which exercises the discarding of unused lanes. A sweep over all nine width pairs with three count and increment variants compares destination memory against byte arithmetic. Directed runs cover error injection, misalignment, illegal width codes, zero count and circular wrap.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic          circ,
  input  logic [CW-1:0] item_count,
  input  logic          ie_half,
  input  logic          ie_done,
  input  logic          ie_err,
  input  logic          clr_half,
  input  logic          clr_done,
  input  logic          clr_err,
  input  logic          ch_gnt,
  output logic          ch_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_done,
  input  logic          mem_err,
  output logic          ch_active,
  output logic [CW-1:0] cnt_left,
  output logic          flag_half,
  output logic          flag_done,
  output logic          flag_err,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] s_ptr, d_ptr, s_base_r, d_base_r;
  logic [1:0]    s_sz, d_sz;
  logic          s_inc, d_inc, circ_r;
  logic [CW-1:0] prog;
  logic [31:0]   data_r;

  function automatic logic is_aligned(input logic [1:0] a, input logic [1:0] sz);
    case (sz)
      2'b00:   return 1'b1;
      2'b01:   return ~a[0];
      2'b10:   return a == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [AW-1:0] step(input logic on, input logic [1:0] sz);
    return on ? (AW'(1) << sz) : '0;
  endfunction

  logic          bad_cfg, start_try, start_go, cfg_err;
  logic          wr_ok, bus_err, set_half, set_done;
  logic [CW-1:0] next_cnt;

  assign bad_cfg   = !is_aligned(src_base[1:0], src_size) || !is_aligned(dst_base[1:0], dst_size);
  assign start_try = start && !ch_active;
  assign cfg_err   = start_try && bad_cfg;
  assign start_go  = start_try && !bad_cfg;

  assign mem_req   = st != S_IDLE;
  assign mem_we    = st == S_WR;
  assign mem_addr  = mem_we ? d_ptr : s_ptr;
  assign mem_size  = mem_we ? d_sz : s_sz;
  assign mem_wdata = data_r & lane_mask(d_sz);
  assign ch_req    = ch_active && st == S_IDLE && cnt_left != '0;

  assign next_cnt  = cnt_left - 1'b1;
  assign wr_ok     = st == S_WR && mem_done && !mem_err;
  assign bus_err   = mem_req && mem_done && mem_err;
  assign set_half  = wr_ok && next_cnt == (prog >> 1);
  assign set_done  = wr_ok && next_cnt == '0;

  assign irq = (flag_half & ie_half) | (flag_done & ie_done) | (flag_err & ie_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_half <= 1'b0;
      flag_done <= 1'b0;
      flag_err  <= 1'b0;
    end else begin
      flag_half <= set_half | (flag_half & ~clr_half);
      flag_done <= set_done | (flag_done & ~clr_done);
      flag_err  <= bus_err | cfg_err | (flag_err & ~clr_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ch_active <= 1'b0;
      cnt_left  <= '0;
      prog      <= '0;
      s_ptr     <= '0;
      d_ptr     <= '0;
      s_base_r  <= '0;
      d_base_r  <= '0;
      s_sz      <= 2'b00;
      d_sz      <= 2'b00;
      s_inc     <= 1'b0;
      d_inc     <= 1'b0;
      circ_r    <= 1'b0;
      data_r    <= '0;
    end else begin
      if (start_go) begin
        ch_active <= item_count != '0;
        cnt_left  <= item_count;
        prog      <= item_count;
        s_ptr     <= src_base;
        d_ptr     <= dst_base;
        s_base_r  <= src_base;
        d_base_r  <= dst_base;
        s_sz      <= src_size;
        d_sz      <= dst_size;
        s_inc     <= src_inc;
        d_inc     <= dst_inc;
        circ_r    <= circ;
      end
      case (st)
        S_IDLE: if (ch_req && ch_gnt) st <= S_RD;
        S_RD: if (mem_done) begin
          if (mem_err) begin
            st        <= S_IDLE;
            ch_active <= 1'b0;
          end else begin
            data_r <= mem_rdata & lane_mask(s_sz);
            st     <= S_WR;
          end
        end
        S_WR: if (mem_done) begin
          st <= S_IDLE;
          if (mem_err) begin
            ch_active <= 1'b0;
          end else if (next_cnt == '0 && circ_r) begin
            cnt_left <= prog;
            s_ptr    <= s_base_r;
            d_ptr    <= d_base_r;
          end else begin
            cnt_left <= next_cnt;
            s_ptr    <= s_ptr + step(s_inc, s_sz);
            d_ptr    <= d_ptr + step(d_inc, d_sz);
            if (next_cnt == '0) ch_active <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_addr_lo,
  input logic [1:0]    mem_size,
  input logic          mem_done,
  input logic          mem_err,
  input logic          ch_active,
  input logic [CW-1:0] cnt_left,
  input logic          flag_half,
  input logic          flag_done,
  input logic          flag_err,
  input logic          irq
);
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'b11); // R2

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size == 2'b00 || (mem_size == 2'b01 && !mem_addr_lo[0]) ||
                 (mem_size == 2'b10 && mem_addr_lo == 2'b00))); // R4

  AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_we) && $stable(mem_addr_lo)); // R3

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_done && !mem_err |=> mem_req && mem_we); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_done && !mem_err |=>
      (cnt_left == $past(cnt_left) - 1'b1) || ($past(cnt_left) == 1)); // R5

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_done && mem_err |=> flag_err && !ch_active && $stable(cnt_left)); // R7

  AST_ZERO_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_left == '0 |-> !mem_req); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_half || flag_done || flag_err)); // R11
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr_lo(mem_addr[1:0]), .mem_size(mem_size), .mem_done(mem_done),
  .mem_err(mem_err), .ch_active(ch_active), .cnt_left(cnt_left),
  .flag_half(flag_half), .flag_done(flag_done), .flag_err(flag_err), .irq(irq)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [1:0] src_size = 0, dst_size = 0;
  logic src_inc = 0, dst_inc = 0, circ = 0;
  logic [CW-1:0] item_count = '0;
  logic ie_half = 0, ie_done = 0, ie_err = 0;
  logic clr_half = 0, clr_done = 0, clr_err = 0;
  logic ch_gnt = 0, ch_req;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic mem_done = 0, mem_err = 0;
  logic ch_active, flag_half, flag_done, flag_err, irq;
  logic [CW-1:0] cnt_left;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) dut_i (.*);

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int acc_cnt = 0, err_at = -1;
  int n_tests = 0, n_fail = 0;

  initial forever begin
    @(negedge clk);
    ch_gnt = ch_req;
    if (mem_req && !mem_done) begin
      mem_done = 1;
      mem_err  = (acc_cnt == err_at);
      acc_cnt++;
      if (!mem_we)
        for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mem[(int'(mem_addr[7:0]) + k) & 255];
      else if (!mem_err)
        for (int k = 0; k < (1 << mem_size); k++) mem[(int'(mem_addr[7:0]) + k) & 255] = mem_wdata[8*k +: 8];
    end else begin
      mem_done = 0;
      mem_err  = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic tick; @(negedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic fill_mem;
    for (int k = 0; k < 256; k++) begin
      mem[k]  = (k < 128) ? 8'(k * 37 + 5) : 8'h00;
      expm[k] = mem[k];
    end
    acc_cnt = 0;
    err_at  = -1;
  endtask

  task automatic clear_flags;
    clr_half = 1; clr_done = 1; clr_err = 1;
    tick;
    clr_half = 0; clr_done = 0; clr_err = 0;
  endtask

  task automatic go(input logic [1:0] ss, input logic [1:0] ds, input bit si, input bit di,
                    input bit cc, input int cnt, input int sb, input int db);
    src_size = ss; dst_size = ds; src_inc = si; dst_inc = di; circ = cc;
    item_count = CW'(cnt); src_base = AW'(sb); dst_base = AW'(db);
    start = 1;
    tick;
    start = 0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (!ch_active) break;
      tick;
    end
  endtask

  function automatic int dst_mismatch;
    int m = 0;
    for (int k = 128; k < 256; k++) if (mem[k] !== expm[k]) m++;
    return m;
  endfunction

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    chk("R1 reset active", ch_active, 0);
    chk("R3 reset req", {ch_req, mem_req}, 0);
    chk("R11 reset flags", {flag_half, flag_done, flag_err, irq}, 0);

    // R3 R5 R6 R8 sweep over all width pairs
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int v = 0; v < 3; v++) begin
          int cnt, mn;
          bit si, di;
          cnt = (v == 0) ? 1 : ((v == 1) ? 3 : 4);
          si = (v != 1);
          di = (v != 2);
          mn = (ss < ds) ? ss : ds;
          fill_mem;
          for (int i = 0; i < cnt; i++) begin
            int sa, da;
            sa = si ? (i << ss) : 0;
            da = 128 + (di ? (i << ds) : 0);
            for (int b = 0; b < (1 << ds); b++)
              expm[da + b] = (b < (1 << mn)) ? mem[sa + b] : 8'h00;
          end
          clear_flags;
          go(2'(ss), 2'(ds), si, di, 0, cnt, 0, 128);
          wait_idle(200);
          tick;
          chk($sformatf("R8 inactive ss=%0d ds=%0d v=%0d", ss, ds, v), ch_active, 0);
          chk("R5 count zero", 32'(cnt_left), 0);
          chk("R8 flags", {flag_half, flag_done, flag_err}, 3'b110);
          chk("R3 access count", acc_cnt, 2 * cnt);
          chk($sformatf("R6 data ss=%0d ds=%0d v=%0d", ss, ds, v), dst_mismatch(), 0);
        end

    // R11 enables and clear
    ie_done = 0;
    #1 chk("R11 irq masked", irq, 0);
    ie_done = 1;
    #1 chk("R11 irq enabled", irq, 1);
    clear_flags;
    chk("R11 cleared", {flag_half, flag_done, irq}, 0);
    ie_done = 0;

    // R1 start capture, ignored restart, R8 half timing
    fill_mem;
    clear_flags;
    go(2, 2, 1, 1, 0, 4, 0, 128);
    chk("R1 active after start", ch_active, 1);
    chk("R1 count loaded", 32'(cnt_left), 4);
    item_count = 9; start = 1;
    tick;
    start = 0;
    chk("R1 restart ignored", 32'(cnt_left), 4);
    for (int i = 0; i < 100 && cnt_left != 2; i++) tick;
    chk("R8 half at 2 of 4", {flag_half, flag_done}, 2'b10);
    wait_idle(200);
    tick;
    chk("R1 only four items", acc_cnt, 8);

    // R7 read error
    fill_mem;
    clear_flags;
    err_at = 2;
    go(2, 2, 1, 1, 0, 3, 0, 128);
    wait_idle(200);
    repeat (20) tick;
    chk("R7 read err flag", {flag_err, flag_done, ch_active}, 3'b100);
    chk("R7 count held", 32'(cnt_left), 2);
    chk("R7 no more access", acc_cnt, 3);

    // R7 write error
    fill_mem;
    clear_flags;
    err_at = 1;
    go(0, 1, 1, 1, 0, 3, 0, 128);
    wait_idle(200);
    repeat (10) tick;
    chk("R7 write err", {flag_err, ch_active}, 2'b10);
    chk("R7 count untouched", 32'(cnt_left), 3);
    chk("R7 nothing written", dst_mismatch(), 0);

    // R9 circular with a stop by error
    fill_mem;
    clear_flags;
    for (int i = 0; i < 5; i++)
      for (int b = 0; b < 4; b++) expm[128 + 4 * (i % 2) + b] = mem[4 * (i % 2) + b];
    err_at = 10;
    go(2, 2, 1, 1, 1, 2, 0, 128);
    for (int i = 0; i < 200 && acc_cnt < 6; i++) tick;
    chk("R9 still active after wrap", ch_active, 1);
    chk("R9 done flag at wrap", flag_done, 1);
    chk("R9 count reloaded", 32'(cnt_left), 2);
    wait_idle(200);
    tick;
    chk("R9 pointers restart", dst_mismatch(), 0);
    chk("R9 accesses", acc_cnt, 11);
    chk("R9 count at stop", 32'(cnt_left), 1);

    // R4 misalignment
    fill_mem;
    clear_flags;
    go(1, 0, 1, 1, 0, 2, 1, 128);
    repeat (10) tick;
    chk("R4 src misaligned", {flag_err, ch_active}, 2'b10);
    chk("R4 no access", acc_cnt, 0);
    ie_err = 0;
    #1 chk("R11 err masked", irq, 0);
    ie_err = 1;
    #1 chk("R11 err irq", irq, 1);
    clear_flags;
    chk("R11 err cleared", {flag_err, irq}, 0);
    go(0, 2, 1, 1, 0, 2, 0, 130);
    repeat (10) tick;
    chk("R4 dst misaligned", {flag_err, ch_active, 32'(acc_cnt)}, {2'b10, 32'd0});
    clear_flags;

    // R2 illegal width code
    go(3, 0, 1, 1, 0, 2, 0, 128);
    repeat (10) tick;
    chk("R2 width 11 src", {flag_err, ch_active, 32'(acc_cnt)}, {2'b10, 32'd0});
    clear_flags;
    go(0, 3, 1, 1, 0, 2, 0, 128);
    repeat (10) tick;
    chk("R2 width 11 dst", {flag_err, ch_active}, 2'b10);
    clear_flags;

    // R10 zero count
    go(2, 2, 1, 1, 0, 0, 0, 128);
    repeat (20) tick;
    chk("R10 zero inactive", {ch_active, ch_req}, 0);
    chk("R10 no events", {flag_half, flag_done, flag_err}, 0);
    chk("R10 no access", acc_cnt, 0);
    ie_err = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule